// File: doc/BRIEF.md
# Dual-Port DRAM Access Arbiter

This block decides who drives a single shared DRAM array: port A, port B, or a refresh cycle. Each port signals that it wants the array by raising its request line together with a row, column and bank address. The block captures that address, picks an owner, raises the row strobe and acknowledges the owning port early, so that the port's bus logic can build its wait or data-ready response from that acknowledge. One grant output tells the board-level address multiplexer which port's address, bank and byte-enable lines to pass on to the array.

Everything runs on one system clock, and both ports are synchronous to it. An access lasts for as long as the owning port keeps its request high. When it drops, the row strobe falls and a precharge of a set number of cycles must pass before the array can be handed out again. A lock input lets the current owner keep the array across several accesses. The other port waits until the lock is released. Refresh requests are queued and win over a new port grant whenever the array is free, but they never cut into a running access.

Top module: `dram_port_arbiter`

## Requirements
- R1: On the clock edge at which a port's request is first sampled high after being low, the block captures that port's row, column and bank inputs. The address outputs show the captured value of the port named by the grant, and later changes on the inputs do not alter it.
- R2: When the array is free and no refresh is wanting, a request sampled high at a rising edge makes the row strobe high from that same edge. A request that has to wait gets the row strobe from the first edge at which the array is free for it.
- R3: ack_a (ack_b) is high exactly while the row strobe is high for a port A (port B) access. It rises together with the row strobe and is never high during a refresh.
- R4: grant_b high means port B owns the array, and low means port A owns it. An acknowledge is only ever given to the port named by grant_b.
- R5: While lock is high, only the port named by grant_b can be granted. The other port's request waits, with its acknowledge low, and is served once lock is low.
- R6: An access ends on the edge at which the owning port's request is sampled low. The row strobe then stays low for exactly PRECHARGE cycles before any new grant or refresh, and it never rises after fewer low cycles.
- R7: A refresh is wanted when refresh_req is high, or has been high since the last refresh started. When the array is free, a wanted refresh wins over any port request. It holds the row strobe high for REF_CYCLES cycles with ref_cycle high, and it never starts while an access is running.
- R8: grant_b changes only on the edge that starts a port access. It never changes while the row strobe stays high.
- R9: When both ports are eligible in the same decision cycle, the port that is not currently named by grant_b (the one that did not own the array last) wins.
- R10: Reset, which is synchronous and active high, leaves the row strobe low, ref_cycle low, both acknowledges low and grant_b low (port A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a | input | 1 | Port A access request, held high for the length of the access |
| row_a | input | ROW_W | Port A row address |
| col_a | input | COL_W | Port A column address |
| bank_a | input | BANK_W | Port A bank select |
| req_b | input | 1 | Port B access request, held high for the length of the access |
| row_b | input | ROW_W | Port B row address |
| col_b | input | COL_W | Port B column address |
| bank_b | input | BANK_W | Port B bank select |
| lock | input | 1 | Owner keeps the array while high |
| refresh_req | input | 1 | Refresh wanted (a pulse is queued) |
| ras | output | 1 | Row strobe, active high |
| ref_cycle | output | 1 | Row strobe belongs to a refresh |
| ack_a | output | 1 | Early acknowledge for port A |
| ack_b | output | 1 | Early acknowledge for port B |
| grant_b | output | 1 | Owner select: 1 = port B, 0 = port A |
| row_o | output | ROW_W | Captured row address of the owning port |
| col_o | output | COL_W | Captured column address of the owning port |
| bank_o | output | BANK_W | Captured bank of the owning port |

## Verification
The main sweep first makes one port the owner. It then ends that access with lock either high or low, and during the precharge it applies every combination of the two requests. The outcome separates the fairness rule (both requesting) from single-port grants, and the locked case from the free one. It also shows that the new grant lands exactly PRECHARGE cycles after the falling strobe. In each case the address outputs show whether the winner's address was captured on its request edge, rather than followed from the live inputs. Two refresh patterns are also tried. In one, a refresh and a port request arrive together at an idle array, which tests priority. In the other, a refresh arrives in the middle of an access, which shows that it waits through the access and the precharge.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACCESS  = 2'd1,
    ST_PRECH   = 2'd2,
    ST_REFRESH = 2'd3
  } arb_state_e;

  localparam int NUM_PORTS = 2;

endpackage

// File: rtl/dpa_addr_latch.sv
module dpa_addr_latch #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic [W-1:0] addr_in,
  output logic [W-1:0] addr_q
);

  logic req_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_d <= req;
      if (req && !req_d) begin
        addr_q <= addr_in;
      end
    end
  end

endmodule

// File: rtl/dpa_pick.sv
module dpa_pick (
  input  logic req_a,
  input  logic req_b,
  input  logic lock,
  input  logic last_b,
  output logic any,
  output logic pick_b
);

  logic elig_a;
  logic elig_b;

  always_comb begin
    elig_a = req_a && !(lock && last_b);
    elig_b = req_b && !(lock && !last_b);
    any    = elig_a || elig_b;
    if (elig_a && elig_b) begin
      pick_b = !last_b;
    end else begin
      pick_b = elig_b;
    end
  end

endmodule

// File: rtl/dpa_cycle_timer.sv
module dpa_cycle_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/dram_port_arbiter.sv
module dram_port_arbiter #(
  parameter int ROW_W      = 9,
  parameter int COL_W      = 9,
  parameter int BANK_W     = 2,
  parameter int PRECHARGE  = 2,
  parameter int REF_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_a,
  input  logic [ROW_W-1:0]  row_a,
  input  logic [COL_W-1:0]  col_a,
  input  logic [BANK_W-1:0] bank_a,
  input  logic              req_b,
  input  logic [ROW_W-1:0]  row_b,
  input  logic [COL_W-1:0]  col_b,
  input  logic [BANK_W-1:0] bank_b,
  input  logic              lock,
  input  logic              refresh_req,
  output logic              ras,
  output logic              ref_cycle,
  output logic              ack_a,
  output logic              ack_b,
  output logic              grant_b,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [BANK_W-1:0] bank_o
);
  import dpa_pkg::*;

  localparam int AW   = ROW_W + COL_W + BANK_W;
  localparam int TMAX = (PRECHARGE > REF_CYCLES) ? PRECHARGE : REF_CYCLES;
  localparam int TW   = (TMAX < 2) ? 1 : $clog2(TMAX + 1);
  localparam logic [TW-1:0] PRE_LOAD = TW'(PRECHARGE - 1);
  localparam logic [TW-1:0] REF_LOAD = TW'(REF_CYCLES - 1);

  initial begin
    if (PRECHARGE < 1 || REF_CYCLES < 1) begin
      $error("PRECHARGE and REF_CYCLES must be at least 1");
    end
  end

  // Per-port address capture
  logic [NUM_PORTS-1:0] port_req;
  logic [AW-1:0]        port_addr [NUM_PORTS];
  logic [AW-1:0]        port_held [NUM_PORTS];

  assign port_req     = {req_b, req_a};
  assign port_addr[0] = {row_a, col_a, bank_a};
  assign port_addr[1] = {row_b, col_b, bank_b};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpa_addr_latch #(.W(AW)) u_latch (
      .clk     (clk),
      .rst     (rst),
      .req     (port_req[p]),
      .addr_in (port_addr[p]),
      .addr_q  (port_held[p])
    );
  end

  assign {row_o, col_o, bank_o} = grant_b ? port_held[1] : port_held[0];

  // Owner choice
  logic any_elig;
  logic pick_b;

  dpa_pick u_pick (
    .req_a  (req_a),
    .req_b  (req_b),
    .lock   (lock),
    .last_b (grant_b),
    .any    (any_elig),
    .pick_b (pick_b)
  );

  // Sequencing
  arb_state_e state;
  logic       ref_pend;
  logic       ref_want;
  logic       tmr_zero;
  logic       tmr_load;
  logic [TW-1:0] tmr_val;
  logic       can_start;
  logic       start_ref;
  logic       start_acc;
  logic       owner_req;
  logic       end_acc;
  logic       end_ref;

  always_comb begin
    ref_want  = ref_pend || refresh_req;
    can_start = (state == ST_IDLE) || (state == ST_PRECH && tmr_zero);
    start_ref = can_start && ref_want;
    start_acc = can_start && !ref_want && any_elig;
    owner_req = grant_b ? req_b : req_a;
    end_acc   = (state == ST_ACCESS) && !owner_req;
    end_ref   = (state == ST_REFRESH) && tmr_zero;
    tmr_load  = start_ref || end_acc || end_ref;
    tmr_val   = start_ref ? REF_LOAD : PRE_LOAD;
  end

  dpa_cycle_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ref_pend  <= 1'b0;
      ras       <= 1'b0;
      ref_cycle <= 1'b0;
      ack_a     <= 1'b0;
      ack_b     <= 1'b0;
      grant_b   <= 1'b0;
    end else begin
      ref_pend <= ref_want && !start_ref;
      if (start_ref) begin
        state     <= ST_REFRESH;
        ras       <= 1'b1;
        ref_cycle <= 1'b1;
      end else if (start_acc) begin
        state   <= ST_ACCESS;
        ras     <= 1'b1;
        grant_b <= pick_b;
        ack_a   <= !pick_b;
        ack_b   <= pick_b;
      end else if (end_acc || end_ref) begin
        state     <= ST_PRECH;
        ras       <= 1'b0;
        ref_cycle <= 1'b0;
        ack_a     <= 1'b0;
        ack_b     <= 1'b0;
      end else if (state == ST_PRECH && tmr_zero) begin
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/dram_port_arbiter_chk.sv
module dram_port_arbiter_chk #(
  parameter int PRECHARGE = 2
) (
  input logic clk,
  input logic rst,
  input logic req_a,
  input logic req_b,
  input logic lock,
  input logic ras,
  input logic ref_cycle,
  input logic ack_a,
  input logic ack_b,
  input logic grant_b
);

  localparam int LW = (PRECHARGE < 2) ? 1 : $clog2(PRECHARGE + 1);
  localparam logic [LW-1:0] LMAX = LW'(PRECHARGE);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= LMAX;
    end else if (ras) begin
      low_cnt <= '0;
    end else if (low_cnt < LMAX) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_ACK_NEEDS_RAS: assert property (@(posedge clk) disable iff (rst)
    (ack_a || ack_b) |-> ras); // R3
  AST_ONE_USER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_a, ack_b, ref_cycle})); // R3
  AST_ACKB_OWNER: assert property (@(posedge clk) disable iff (rst)
    ack_b |-> grant_b); // R4
  AST_ACKA_OWNER: assert property (@(posedge clk) disable iff (rst)
    ack_a |-> !grant_b); // R4
  AST_ACKA_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_a) |-> $past(req_a)); // R2
  AST_ACKB_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_b) |-> $past(req_b)); // R2
  AST_LOCK_HOLDS_B_OUT: assert property (@(posedge clk) disable iff (rst)
    (lock && !grant_b) |=> !ack_b); // R5
  AST_LOCK_HOLDS_A_OUT: assert property (@(posedge clk) disable iff (rst)
    (lock && grant_b) |=> !ack_a); // R5
  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(ras) |-> (low_cnt >= LMAX)); // R6
  AST_NO_REFRESH_CUT: assert property (@(posedge clk) disable iff (rst)
    (ack_a || ack_b) |=> !ref_cycle); // R7
  AST_GRANT_STEADY: assert property (@(posedge clk) disable iff (rst)
    (ras && $past(ras)) |-> $stable(grant_b)); // R8

endmodule

bind dram_port_arbiter dram_port_arbiter_chk #(.PRECHARGE(PRECHARGE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_a     (req_a),
  .req_b     (req_b),
  .lock      (lock),
  .ras       (ras),
  .ref_cycle (ref_cycle),
  .ack_a     (ack_a),
  .ack_b     (ack_b),
  .grant_b   (grant_b)
);

// File: tb/tb_dram_port_arbiter.sv
module tb_dram_port_arbiter;

  localparam int RW   = 9;
  localparam int CW   = 9;
  localparam int BW   = 2;
  localparam int PRE  = 2;
  localparam int REFC = 3;
  localparam int AW   = RW + CW + BW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic          req_a, req_b, lock, refresh_req;
  logic [RW-1:0] row_a, row_b, row_o;
  logic [CW-1:0] col_a, col_b, col_o;
  logic [BW-1:0] bank_a, bank_b, bank_o;
  logic          ras, ref_cycle, ack_a, ack_b, grant_b;

  dram_port_arbiter #(
    .ROW_W(RW), .COL_W(CW), .BANK_W(BW), .PRECHARGE(PRE), .REF_CYCLES(REFC)
  ) dut (
    .clk(clk), .rst(rst),
    .req_a(req_a), .row_a(row_a), .col_a(col_a), .bank_a(bank_a),
    .req_b(req_b), .row_b(row_b), .col_b(col_b), .bank_b(bank_b),
    .lock(lock), .refresh_req(refresh_req),
    .ras(ras), .ref_cycle(ref_cycle), .ack_a(ack_a), .ack_b(ack_b),
    .grant_b(grant_b), .row_o(row_o), .col_o(col_o), .bank_o(bank_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int seed);
    return AW'(seed * 40503 + 977);
  endfunction

  task automatic set_a(input logic [AW-1:0] v);
    {row_a, col_a, bank_a} = v;
  endtask

  task automatic set_b(input logic [AW-1:0] v);
    {row_b, col_b, bank_b} = v;
  endtask

  task automatic drain();
    req_a = 1'b0; req_b = 1'b0; lock = 1'b0; refresh_req = 1'b0;
    step(PRE + REFC + 4);
  endtask

  // R8 monitor: grant must not move while the strobe stays high
  logic pr_ras = 1'b0;
  logic pr_gnt = 1'b0;
  always @(negedge clk) begin
    if (!rst && pr_ras && ras) begin
      checks++;
      if (grant_b !== pr_gnt) begin
        fails++;
        $display("FAIL R8 grant moved under ras actual=%0h expected=%0h", grant_b, pr_gnt);
      end
    end
    pr_ras <= ras;
    pr_gnt <= grant_b;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_a = 0; req_b = 0; lock = 0; refresh_req = 0;
    set_a('0); set_b('0);
    step(3);
    rst = 1'b0;
    step(1);
    chk("R10", "ras after reset", ras, 0);
    chk("R10", "ref_cycle after reset", ref_cycle, 0);
    chk("R10", "ack_a after reset", ack_a, 0);
    chk("R10", "ack_b after reset", ack_b, 0);
    chk("R10", "grant_b after reset", grant_b, 0);

    // Sweep: previous owner x request pattern x lock
    for (int own = 0; own < 2; own++) begin
      for (int pat = 0; pat < 4; pat++) begin
        for (int lk = 0; lk < 2; lk++) begin
          int it;
          logic [AW-1:0] va, vb, vexp;
          logic ea, eb, ex_any, ex_b;
          it = own * 8 + pat * 2 + lk;
          drain();
          // make 'own' the owner
          if (own == 0) begin set_a(mk_addr(it + 100)); req_a = 1; end
          else          begin set_b(mk_addr(it + 200)); req_b = 1; end
          step(1);
          chk("R2", "ras on free grant", ras, 1);
          chk("R4", "grant_b names owner", grant_b, own[0]);
          chk("R3", "owner ack", own ? ack_b : ack_a, 1);
          lock = lk[0];
          req_a = 0; req_b = 0;
          step(1);
          chk("R6", "ras low after drop", ras, 0);
          va = mk_addr(it * 3 + 1);
          vb = mk_addr(it * 5 + 2);
          set_a(va); set_b(vb);
          req_a = pat[0]; req_b = pat[1];
          step(PRE - 1);
          chk("R6", "ras low during precharge", ras, 0);
          step(1);
          ea = pat[0] && !(lk && own == 1);
          eb = pat[1] && !(lk && own == 0);
          ex_any = ea || eb;
          ex_b = (ea && eb) ? (own == 0) : eb;
          chk((ea && eb) ? "R9" : "R5", "ras after precharge", ras, ex_any);
          if (ex_any) begin
            chk("R9", "winner ack_b", ack_b, ex_b);
            chk("R9", "winner ack_a", ack_a, !ex_b);
            chk("R4", "grant_b after decision", grant_b, ex_b);
            vexp = ex_b ? vb : va;
            chk("R1", "captured address", {row_o, col_o, bank_o}, vexp);
            set_a(~va); set_b(~vb);
            step(1);
            chk("R1", "address held after input change", {row_o, col_o, bank_o}, vexp);
          end else if (lk && pat != 0) begin
            step(3);
            chk("R5", "waiting port held under lock", ras, 0);
            lock = 0;
            step(1);
            chk("R5", "waiting port served after unlock", ras, 1);
            chk("R5", "waiting port ack", own ? ack_a : ack_b, 1);
            chk("R1", "waiting port address", {row_o, col_o, bank_o}, own ? va : vb);
          end
        end
      end
    end

    // Refresh and port A arrive together at a free array
    drain();
    set_a(mk_addr(77));
    refresh_req = 1; req_a = 1;
    step(1);
    refresh_req = 0;
    chk("R7", "refresh wins free array", ref_cycle, 1);
    chk("R7", "ras during refresh", ras, 1);
    chk("R3", "no ack during refresh", ack_a, 0);
    step(REFC - 1);
    chk("R7", "refresh still running", ref_cycle & ras, 1);
    step(1);
    chk("R7", "refresh length", ras, 0);
    step(PRE - 1);
    chk("R6", "precharge after refresh", ras, 0);
    step(1);
    chk("R2", "waiting A served after refresh", ack_a, 1);
    chk("R1", "A address after refresh", {row_o, col_o, bank_o}, mk_addr(77));

    // Refresh arrives during a port B access
    drain();
    req_b = 1;
    step(1);
    chk("R3", "B ack", ack_b, 1);
    refresh_req = 1;
    step(1);
    refresh_req = 0;
    step(3);
    chk("R7", "refresh does not cut access", ref_cycle, 0);
    chk("R7", "access continues", ack_b, 1);
    req_b = 0; req_a = 1;
    step(1);
    chk("R6", "ras low after B drop", ras, 0);
    step(PRE - 1);
    chk("R6", "ras low in precharge", ras, 0);
    step(1);
    chk("R7", "queued refresh beats A", ref_cycle, 1);
    chk("R7", "A waits for refresh", ack_a, 0);

    drain();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule